// File: doc/BRIEF.md
# Start/Done Framed Data Accumulator

This block adds up a stream of 8-bit unsigned samples into a wide running total. Two single-cycle control strobes mark each run. A `start` strobe clears the total and opens a run. A `done` strobe closes the run. The total then stays frozen on the output until the next `start`.

Inside, a two-state controller (idle / running) decides on each clock edge whether the total register is cleared, loaded with total plus sample, or left as it is. The sample width and the total width are parameters. Samples are zero-extended before they are added, and the total wraps modulo 2^ACC_W.

The reset is synchronous and active-low. A run may be restarted at any time by another `start`.

Top module: `framed_accum`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `acc` becomes zero after that edge and the controller goes idle. This applies even in the middle of a run.
- R2: While idle, `acc` does not change at any edge where `start` is low. A `done` strobe or any `d_in` value seen while idle has no effect.
- R3: At an edge where `start` is high, `acc` becomes zero. The `d_in` value present in that cycle is not added.
- R4: At every edge after the `start` edge, up to and including the `done` edge, `acc` becomes the old `acc` plus `d_in` zero-extended to ACC_W bits.
- R5: The `d_in` value present at the edge where `done` is high during a run is added. From the next edge on, no further samples are added.
- R6: After a run ends, `acc` keeps its final value until the next `start` edge.
- R7: A `start` during a run restarts it: `acc` becomes zero, that cycle's sample is dropped, and accumulation continues from the next edge.
- R8: When `start` and `done` are both high at the same edge, `start` wins. This holds both from idle and during a run: `acc` is cleared and a run is open afterwards.
- R9: A run with `done` on the first cycle after `start` ends with `acc` equal to that single sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Strobe: clear the total and open a run |
| done | input | 1 | Strobe: include this sample and close the run |
| d_in | input | DATA_W (8) | Unsigned sample |
| acc | output | ACC_W (64) | Registered running total |

## Verification
The controller state can only be seen through `acc`. If the state is wrong, the effect appears at the first edge where the state matters.

A controller stuck in running keeps adding after `done`, so `acc` moves during the hold period on the next cycle with a nonzero sample. A controller stuck in idle leaves `acc` at zero on the first sample after `start`. A misplaced clear or add shifts the total by exactly one sample.

Because `acc` is compared with a reference model after every edge, each of these faults shows up within one cycle of where it first matters.

// File: rtl/framed_accum_pkg.sv
package framed_accum_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/framed_accum_ctrl.sv
module framed_accum_ctrl
  import framed_accum_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic clr_o,
  output logic add_o,
  output logic running_o
);
  run_state_e state_q, state_d;

  // start has priority over done in every state
  always_comb begin
    state_d = state_q;
    if (start)
      state_d = ST_RUN;
    else if (state_q == ST_RUN && done)
      state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign clr_o     = start;
  assign add_o     = (state_q == ST_RUN) && !start;
  assign running_o = (state_q == ST_RUN);

  // R8: start always opens a run, whatever done does
  p_start_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> running_o);

  // R5: done closes a run unless start is present too
  p_done_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && done && !start) |=> !running_o);

  // R2: idle persists without start
  p_idle_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !start) |=> !running_o);
endmodule

// File: rtl/framed_accum_dp.sv
module framed_accum_dp #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [DATA_W-1:0] d_in,
  output logic [ACC_W-1:0]  acc_o
);
  localparam int PAD_W = ACC_W - DATA_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sample_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign sample_ext = {{PAD_W{1'b0}}, d_in};
    end else begin : g_nopad
      assign sample_ext = d_in[ACC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else if (add) acc_q <= acc_q + sample_ext;
  end

  assign acc_o = acc_q;

  // R1: one edge after reset is sampled low, the total must read zero
  logic rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= !rst_n;
  always_ff @(posedge clk)
    if (rst_seen_q) a_reset_zero_r1: assert (acc_q == '0);

  // R3: clear on start
  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_o == '0));

  // R4: each enabled cycle adds the zero-extended sample
  p_add_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clr) |=> (acc_o == $past(acc_o) + ACC_W'($past(d_in))));

  // R6: hold when neither clearing nor adding
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!add && !clr) |=> $stable(acc_o));
endmodule

// File: rtl/framed_accum.sv
module framed_accum #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              done,
  input  logic [DATA_W-1:0] d_in,
  output logic [ACC_W-1:0]  acc
);
  logic clr, add, running;

  framed_accum_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .clr_o     (clr),
    .add_o     (add),
    .running_o (running)
  );

  framed_accum_dp #(
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W)
  ) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .add   (add),
    .d_in  (d_in),
    .acc_o (acc)
  );

  // R7: start during a run drops the sample and zeroes the total
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start) |=> (acc == '0));

  // R2: an idle block ignores done and data
  p_idle_ignores_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(acc));
endmodule

// File: tb/framed_accum_test.sv
module framed_accum_test;
  localparam int DATA_W = 8;
  localparam int ACC_W  = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic              done;
  logic [DATA_W-1:0] d_in;
  logic [ACC_W-1:0]  acc;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [ACC_W-1:0] exp_q[$];
  string            tag_q[$];

  logic [ACC_W-1:0] m_acc = '0;
  bit               m_run = 1'b0;

  always #5 clk = ~clk;

  framed_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .d_in(d_in), .acc(acc)
  );

  // Driver: apply one cycle of stimulus and queue the expected post-edge total
  task automatic step(input bit r, input bit s, input bit dn,
                      input logic [DATA_W-1:0] d, input string tag);
    @(negedge clk);
    rst_n = r; start = s; done = dn; d_in = d;
    if (!r) begin
      m_acc = '0; m_run = 1'b0;
    end else if (s) begin
      m_acc = '0; m_run = 1'b1;
    end else if (m_run) begin
      m_acc = m_acc + ACC_W'(d);
      if (dn) m_run = 1'b0;
    end
    exp_q.push_back(m_acc);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [ACC_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (acc !== e) begin
          errors++;
          $display("FAIL %s: acc actual %0d expected %0d", t, acc, e);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; done = 1'b0; d_in = '0;
    // R1: reset state
    for (int i = 0; i < 3; i++) step(0, 0, 0, 8'd9, "R1");
    // R2: idle ignores data and done
    step(1, 0, 0, 8'd50, "R2");
    step(1, 0, 1, 8'd60, "R2");
    step(1, 0, 0, 8'd70, "R2");
    // R3: start clears, its sample excluded
    step(1, 1, 0, 8'd200, "R3");
    // R4: accumulate
    step(1, 0, 0, 8'd10, "R4");
    step(1, 0, 0, 8'd20, "R4");
    step(1, 0, 0, 8'd30, "R4");
    // R5: done sample included
    step(1, 0, 1, 8'd40, "R5");
    // R6: hold after done
    step(1, 0, 0, 8'd99, "R6");
    step(1, 0, 1, 8'd88, "R6");
    step(1, 0, 0, 8'd255, "R6");
    // R9: single-sample run
    step(1, 1, 0, 8'd5, "R3");
    step(1, 0, 1, 8'd77, "R9");
    step(1, 0, 0, 8'd33, "R6");
    // R7: restart mid-run
    step(1, 1, 0, 8'd1, "R3");
    step(1, 0, 0, 8'd100, "R4");
    step(1, 0, 0, 8'd101, "R4");
    step(1, 1, 0, 8'd150, "R7");
    step(1, 0, 0, 8'd3, "R7");
    step(1, 0, 1, 8'd4, "R7");
    step(1, 0, 0, 8'd12, "R6");
    // R8: start and done together from idle, then during a run
    step(1, 1, 1, 8'd66, "R8");
    step(1, 0, 0, 8'd7, "R8");
    step(1, 1, 1, 8'd8, "R8");
    step(1, 0, 0, 8'd9, "R8");
    step(1, 0, 1, 8'd11, "R5");
    step(1, 0, 0, 8'd13, "R6");
    // R1: reset mid-run
    step(1, 1, 0, 8'd0, "R3");
    step(1, 0, 0, 8'd200, "R4");
    step(0, 0, 0, 8'd200, "R1");
    step(1, 0, 0, 8'd200, "R2");
    // Back-to-back runs with full-scale samples
    for (int k = 0; k < 3; k++) begin
      step(1, 1, 0, 8'd255, "R3");
      for (int i = 0; i < 200; i++) step(1, 0, 0, 8'(255 - i), "R4");
      step(1, 0, 1, 8'd255, "R5");
    end
    step(1, 0, 0, 8'd1, "R6");
    step(1, 0, 0, 8'd2, "R6");
    @(posedge clk);
    #4;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual incomplete run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule